// File: doc/BRIEF.md
# Board Control Strobe Sequencer

This block owns an 8-bit control register that reaches simple latch logic on the board. It carries low-order handshake bits and high-order data bits. A write request produces a four-step pattern on the register. A read request produces a two-step pattern. In the read, the board's answer on the input port is captured at the end of the select step. A cable-detect request runs a fixed program that chains writes and reads. It selects bank 0 of the board's sense multiplexer, reads it, switches to bank 1, reads again, and then decodes four presence flags.

The handshake pattern depends on the chip variant. The variant, the channel select, the write data and the step hold time are all captured when a request is accepted. Each step stays on the register for a programmable number of cycles, so that slow board logic can latch the value. While a sequence runs, `busy` is high and any new request is dropped.

Top module: `board_strobe_seq`

## Requirements
- R1: After reset, and whenever no sequence runs, `brdOut` is 0 and `busy`, `rdValid` and `detValid` are 0.
- R2: A request is accepted at a clock edge only while `busy` is low. The next cycle shows the first step. Every step is held for `holdCycles`+1 cycles. `busy` stays high through the last step and drops in the cycle after it. A request raised while `busy` is high has no effect.
- R3: Standard write (`variant` 0 or 3), with strobe = bit 0, select = bit 1 and data D: 0x03, then 0x03|D, then that value with bit 0 cleared, then that value with bits 0 and 1 cleared.
- R4: Dual-channel write (`variant` 1) follows R3. The only difference is that bit 1 is set only when `chanB` is 1.
- R5: Ultra2 write (`variant` 2): 0x00, then D, then D with bit 2 (the ultra2 strobe) set, then 0x00.
- R6: A read shows a select step and then a 0x00 step. The select step is 0x04|0x02 on standard parts, 0x04 plus bit 1 only for channel B on dual-channel parts, and 0x01 on ultra2 parts. `brdIn` is captured in the last cycle of the select step. It appears on `rdData` when `rdValid` pulses, in the cycle after the sequence.
- R7: Cable detect runs, in order: a write of 0x00, a read, a write of 0x20 (bank select = bit 5), and a read. That is 12 steps, each formed as in R3 to R6 for the variant.
- R8: Detect decoding, from the bank 0 sample: narrow internal cable present = bit 6 low, wide internal cable present = bit 7 low. From the bank 1 sample: external cable present = bit 6 low, boot ROM present = bit 7 high. The flags are valid when `detValid` pulses, in the cycle after the sequence.
- R9: Requests in the same cycle are resolved with detect first, then read, then write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| variant | input | 2 | 0 standard, 1 dual-channel, 2 ultra2, 3 standard |
| chanB | input | 1 | Channel B select for dual-channel parts |
| holdCycles | input | HOLD_W | Extra cycles each step is held |
| wrData | input | 8 | Data ORed into the write steps |
| reqWrite | input | 1 | Start a write sequence |
| reqRead | input | 1 | Start a read sequence |
| reqDetect | input | 1 | Start the cable-detect program |
| brdIn | input | 8 | Value read back from the board register |
| brdOut | output | 8 | Value driven onto the board register |
| busy | output | 1 | A sequence is in progress |
| rdData | output | 8 | Captured read value |
| rdValid | output | 1 | One-cycle pulse after a read sequence |
| detValid | output | 1 | One-cycle pulse after a detect program |
| int50Present | output | 1 | Narrow internal cable sensed |
| int68Present | output | 1 | Wide internal cable sensed |
| extPresent | output | 1 | External cable sensed |
| romPresent | output | 1 | Boot ROM sensed |

## Verification
Two events can fall in the same cycle: the end of a running sequence and a fresh request. The bench raises a request during the final busy cycle of a sequence, and also during its first busy cycle. It then expects `brdOut` to return to 0 with `busy` low, and the result pulse to appear exactly once. A second pair is several requests raised together. The bench expects the step pattern of the higher-priority sequence, cycle for cycle.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int REG_W      = 8;
  localparam int STB_BIT    = 0;
  localparam int CS_BIT     = 1;
  localparam int RW_BIT     = 2;
  localparam int U2_STB_BIT = 2;
  localparam int U2_RW_BIT  = 0;
  localparam int BANK_BIT   = 5;
  localparam int SENSE_LO   = 6;
  localparam int SENSE_HI   = 7;
  localparam logic [1:0] VAR_DUAL = 2'd1;
  localparam logic [1:0] VAR_U2   = 2'd2;
  localparam logic [1:0] WR_LAST  = 2'd3;
  localparam logic [1:0] RD_LAST  = 2'd1;

  typedef enum logic [1:0] {PH_IDLE, PH_WR, PH_RD} phase_e;

  typedef struct packed {
    logic       accept;
    phase_e     phase;
    logic [1:0] step;
    logic       bank;
    logic       isDetect;
    logic       sample;
    logic       finish;
  } seq_ctl_t;
endpackage

// File: rtl/bss_ctrl.sv
module bss_ctrl
  import bss_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic              reqRead,
  input  logic              reqDetect,
  input  logic [HOLD_W-1:0] holdCycles,
  output seq_ctl_t          ctl,
  output logic              busy
);
  phase_e            phase;
  logic [1:0]        step;
  logic              bank;
  logic              isDetect;
  logic [HOLD_W-1:0] cnt;
  logic [HOLD_W-1:0] holdReg;
  logic              accept, lastCyc, wrEnd, rdEnd, moreBanks;

  always_comb begin
    accept    = (phase == PH_IDLE) && (reqWrite || reqRead || reqDetect);
    lastCyc   = (cnt == holdReg);
    wrEnd     = (phase == PH_WR) && (step == WR_LAST) && lastCyc;
    rdEnd     = (phase == PH_RD) && (step == RD_LAST) && lastCyc;
    moreBanks = isDetect && !bank;
    busy      = (phase != PH_IDLE);
    ctl.accept   = accept;
    ctl.phase    = phase;
    ctl.step     = step;
    ctl.bank     = bank;
    ctl.isDetect = isDetect;
    ctl.sample   = (phase == PH_RD) && (step == 2'd0) && lastCyc;
    ctl.finish   = (wrEnd && !isDetect) || (rdEnd && !moreBanks);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      step     <= '0;
      bank     <= 1'b0;
      isDetect <= 1'b0;
      cnt      <= '0;
      holdReg  <= '0;
    end else if (accept) begin
      holdReg  <= holdCycles;
      cnt      <= '0;
      step     <= '0;
      bank     <= 1'b0;
      isDetect <= reqDetect;
      phase    <= (reqDetect || !reqRead) ? PH_WR : PH_RD;
    end else if (busy) begin
      if (!lastCyc) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (phase == PH_WR) begin
          if (step != WR_LAST) step <= step + 1'b1;
          else if (isDetect) begin
            phase <= PH_RD;
            step  <= '0;
          end else phase <= PH_IDLE;
        end else begin
          if (step != RD_LAST) step <= step + 1'b1;
          else if (moreBanks) begin
            bank  <= 1'b1;
            phase <= PH_WR;
            step  <= '0;
          end else phase <= PH_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/bss_dpath.sv
module bss_dpath
  import bss_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seq_ctl_t         ctl,
  input  logic [1:0]       variant,
  input  logic             chanB,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] brdIn,
  output logic [REG_W-1:0] brdOut,
  output logic [REG_W-1:0] rdData,
  output logic             rdValid,
  output logic             detValid,
  output logic             int50Present,
  output logic             int68Present,
  output logic             extPresent,
  output logic             romPresent
);
  logic [1:0]       varReg;
  logic             chanReg;
  logic [REG_W-1:0] dataReg;
  logic             isU2, csOn;
  logic [REG_W-1:0] selBits, baseWr, valWr, dataNow, rdSel;

  always_comb begin
    isU2    = (varReg == VAR_U2);
    csOn    = (varReg == VAR_DUAL) ? chanReg : 1'b1;
    selBits = '0;
    selBits[CS_BIT] = csOn;
    dataNow = dataReg;
    if (ctl.isDetect) begin
      dataNow = '0;
      dataNow[BANK_BIT] = ctl.bank;
    end
    baseWr = selBits;
    baseWr[STB_BIT] = 1'b1;
    if (isU2) baseWr = '0;
    valWr = baseWr | dataNow;
    rdSel = selBits;
    rdSel[RW_BIT] = 1'b1;
    if (isU2) begin
      rdSel = '0;
      rdSel[U2_RW_BIT] = 1'b1;
    end
    brdOut = '0;
    if (ctl.phase == PH_WR) begin
      case (ctl.step)
        2'd0: brdOut = baseWr;
        2'd1: brdOut = valWr;
        2'd2: begin
          brdOut = valWr;
          if (isU2) brdOut[U2_STB_BIT] = 1'b1;
          else      brdOut[STB_BIT]    = 1'b0;
        end
        default: begin
          brdOut = valWr;
          brdOut[STB_BIT] = 1'b0;
          brdOut[CS_BIT]  = 1'b0;
          if (isU2) brdOut = '0;
        end
      endcase
    end else if (ctl.phase == PH_RD && ctl.step == 2'd0) begin
      brdOut = rdSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      varReg       <= '0;
      chanReg      <= 1'b0;
      dataReg      <= '0;
      rdData       <= '0;
      rdValid      <= 1'b0;
      detValid     <= 1'b0;
      int50Present <= 1'b0;
      int68Present <= 1'b0;
      extPresent   <= 1'b0;
      romPresent   <= 1'b0;
    end else begin
      if (ctl.accept) begin
        varReg  <= variant;
        chanReg <= chanB;
        dataReg <= wrData;
      end
      if (ctl.sample) begin
        if (!ctl.isDetect) rdData <= brdIn;
        else if (!ctl.bank) begin
          int50Present <= ~brdIn[SENSE_LO];
          int68Present <= ~brdIn[SENSE_HI];
        end else begin
          extPresent <= ~brdIn[SENSE_LO];
          romPresent <= brdIn[SENSE_HI];
        end
      end
      rdValid  <= ctl.finish && (ctl.phase == PH_RD) && !ctl.isDetect;
      detValid <= ctl.finish && ctl.isDetect;
    end
  end
endmodule

// File: rtl/board_strobe_seq.sv
module board_strobe_seq
  import bss_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        variant,
  input  logic              chanB,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [REG_W-1:0]  wrData,
  input  logic              reqWrite,
  input  logic              reqRead,
  input  logic              reqDetect,
  input  logic [REG_W-1:0]  brdIn,
  output logic [REG_W-1:0]  brdOut,
  output logic              busy,
  output logic [REG_W-1:0]  rdData,
  output logic              rdValid,
  output logic              detValid,
  output logic              int50Present,
  output logic              int68Present,
  output logic              extPresent,
  output logic              romPresent
);
  seq_ctl_t ctl;

  bss_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqRead(reqRead),
    .reqDetect(reqDetect), .holdCycles(holdCycles), .ctl(ctl), .busy(busy)
  );

  bss_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .variant(variant), .chanB(chanB),
    .wrData(wrData), .brdIn(brdIn), .brdOut(brdOut), .rdData(rdData),
    .rdValid(rdValid), .detValid(detValid), .int50Present(int50Present),
    .int68Present(int68Present), .extPresent(extPresent), .romPresent(romPresent)
  );
endmodule

// File: rtl/bss_chk.sv
module bss_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqWrite,
  input logic       reqRead,
  input logic       reqDetect,
  input logic       busy,
  input logic [7:0] brdOut,
  input logic       rdValid,
  input logic       detValid
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (brdOut == 8'h00));

  assert_start_on_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqWrite || reqRead || reqDetect));

  assert_read_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busy);

  assert_detect_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    detValid |-> !busy);

  assert_single_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdValid, detValid}));
endmodule

bind board_strobe_seq bss_chk u_chk (
  .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqRead(reqRead),
  .reqDetect(reqDetect), .busy(busy), .brdOut(brdOut),
  .rdValid(rdValid), .detValid(detValid)
);

// File: tb/board_strobe_seq_test.sv
module board_strobe_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] variant = 2'd0;
  logic chanB = 1'b0;
  logic [HOLD_W-1:0] holdCycles = '0;
  logic [7:0] wrData = 8'h00;
  logic reqWrite = 1'b0, reqRead = 1'b0, reqDetect = 1'b0;
  logic [7:0] brdIn, brdOut, rdData;
  logic busy, rdValid, detValid, int50Present, int68Present, extPresent, romPresent;

  logic [7:0] bank0Val = 8'h00, bank1Val = 8'h00;
  logic bankSel = 1'b0;
  logic [1:0] curVar = 2'd0;
  int checkCount = 0, failCount = 0;

  logic [7:0] expOut[$];
  logic [2:0] expFlags[$];
  string      expTag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  board_strobe_seq #(.HOLD_W(HOLD_W)) uut (
    .clk(clk), .rstN(rstN), .variant(variant), .chanB(chanB),
    .holdCycles(holdCycles), .wrData(wrData), .reqWrite(reqWrite),
    .reqRead(reqRead), .reqDetect(reqDetect), .brdIn(brdIn), .brdOut(brdOut),
    .busy(busy), .rdData(rdData), .rdValid(rdValid), .detValid(detValid),
    .int50Present(int50Present), .int68Present(int68Present),
    .extPresent(extPresent), .romPresent(romPresent)
  );

  // Board model: latches the bank bit while a strobe is shown.
  assign brdIn = bankSel ? bank1Val : bank0Val;
  always @(posedge clk) begin
    if ((curVar == 2'd2) ? brdOut[2] : brdOut[0]) bankSel <= brdOut[5];
  end

  function automatic logic [7:0] expWr(input logic [1:0] vr, input logic ch,
                                       input logic [7:0] d, input int k);
    logic [7:0] base;
    if (vr == 2'd2) begin
      case (k)
        0: return 8'h00;
        1: return d;
        2: return d | 8'h04;
        default: return 8'h00;
      endcase
    end
    base = 8'h01 | (((vr == 2'd1) && !ch) ? 8'h00 : 8'h02);
    case (k)
      0: return base;
      1: return base | d;
      2: return (base | d) & 8'hFE;
      default: return (base | d) & 8'hFC;
    endcase
  endfunction

  function automatic logic [7:0] expRd(input logic [1:0] vr, input logic ch);
    if (vr == 2'd2) return 8'h01;
    return 8'h04 | (((vr == 2'd1) && !ch) ? 8'h00 : 8'h02);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares {brdOut, busy, rdValid, detValid} every cycle.
  always @(negedge clk) begin
    if (expOut.size() != 0) begin
      logic [7:0] eo;
      logic [2:0] ef;
      string t;
      eo = expOut.pop_front();
      ef = expFlags.pop_front();
      t  = expTag.pop_front();
      check(t, {brdOut, busy, rdValid, detValid}, {eo, ef});
    end
  end

  task automatic push(input logic [7:0] o, input logic [2:0] f, input string t);
    expOut.push_back(o);
    expFlags.push_back(f);
    expTag.push_back(t);
  endtask

  task automatic pushStep(input logic [7:0] o, input int hold, input string t);
    for (int i = 0; i <= hold; i++) push(o, 3'b100, t);
  endtask

  task automatic pushWrite(input logic [1:0] vr, input logic ch, input logic [7:0] d,
                           input int hold, input string t);
    for (int k = 0; k < 4; k++) pushStep(expWr(vr, ch, d, k), hold, t);
  endtask

  task automatic pushRead(input logic [1:0] vr, input logic ch, input int hold, input string t);
    pushStep(expRd(vr, ch), hold, t);
    pushStep(8'h00, hold, t);
  endtask

  // Driver: reqMask = {detect, read, write}.
  task automatic runOp(input logic [2:0] reqMask, input logic [1:0] vr, input logic ch,
                       input logic [7:0] d, input int hold, input bit poke, input string t);
    int busyLen;
    logic [7:0] rdExp;
    @(negedge clk);
    variant = vr; chanB = ch; wrData = d; holdCycles = hold[HOLD_W-1:0];
    curVar = vr;
    rdExp = bankSel ? bank1Val : bank0Val;
    {reqDetect, reqRead, reqWrite} = reqMask;
    @(posedge clk);
    #1;
    {reqDetect, reqRead, reqWrite} = 3'b000;
    if (reqMask[2]) begin
      pushWrite(vr, ch, 8'h00, hold, t);
      pushRead(vr, ch, hold, t);
      pushWrite(vr, ch, 8'h20, hold, t);
      pushRead(vr, ch, hold, t);
      push(8'h00, 3'b001, t);
    end else if (reqMask[1]) begin
      pushRead(vr, ch, hold, t);
      push(8'h00, 3'b010, t);
    end else begin
      pushWrite(vr, ch, d, hold, t);
      push(8'h00, 3'b000, t);
    end
    push(8'h00, 3'b000, t);
    busyLen = expOut.size() - 2;
    if (poke) begin
      @(negedge clk);
      reqWrite = 1'b1;
      @(posedge clk); #1 reqWrite = 1'b0;
      repeat (busyLen - 1) @(negedge clk);
      reqRead = 1'b1;
      @(posedge clk); #1 reqRead = 1'b0;
    end
    while (expOut.size() != 0) @(posedge clk);
    @(negedge clk);
    if (reqMask[1] && !reqMask[2]) check({t, " R6 rdData"}, {24'h0, rdData}, {24'h0, rdExp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", {brdOut, busy, rdValid, detValid}, {8'h00, 3'b000});

    runOp(3'b001, 2'd0, 1'b0, 8'hA8, 0, 0, "R3 std write hold0");
    runOp(3'b001, 2'd3, 1'b0, 8'h58, 2, 0, "R3 R2 std write hold2");
    runOp(3'b001, 2'd1, 1'b0, 8'h50, 1, 0, "R4 dual chanA write");
    runOp(3'b001, 2'd1, 1'b1, 8'h90, 0, 0, "R4 dual chanB write");
    runOp(3'b001, 2'd2, 1'b0, 8'hF8, 1, 0, "R5 ultra2 write");

    bank0Val = 8'h5A; bank1Val = 8'h5A;
    runOp(3'b010, 2'd0, 1'b0, 8'h00, 0, 0, "R6 std read");
    bank0Val = 8'hC3; bank1Val = 8'hC3;
    runOp(3'b010, 2'd1, 1'b1, 8'h00, 2, 0, "R6 dual chanB read");
    runOp(3'b010, 2'd1, 1'b0, 8'h00, 0, 0, "R6 dual chanA read");
    bank0Val = 8'h3C; bank1Val = 8'h3C;
    runOp(3'b010, 2'd2, 1'b0, 8'h00, 1, 0, "R6 ultra2 read");

    bank0Val = 8'h40; bank1Val = 8'h80;
    runOp(3'b100, 2'd0, 1'b0, 8'h00, 0, 0, "R7 std detect");
    check("R8 narrow", {31'h0, int50Present}, 32'd0);
    check("R8 wide", {31'h0, int68Present}, 32'd1);
    check("R8 external", {31'h0, extPresent}, 32'd1);
    check("R8 rom", {31'h0, romPresent}, 32'd1);

    bank0Val = 8'h80; bank1Val = 8'h40;
    runOp(3'b100, 2'd2, 1'b0, 8'h00, 1, 0, "R7 ultra2 detect");
    check("R8 narrow u2", {31'h0, int50Present}, 32'd1);
    check("R8 wide u2", {31'h0, int68Present}, 32'd0);
    check("R8 external u2", {31'h0, extPresent}, 32'd0);
    check("R8 rom u2", {31'h0, romPresent}, 32'd0);

    bank0Val = 8'h11; bank1Val = 8'h11;
    runOp(3'b011, 2'd0, 1'b0, 8'hF0, 0, 0, "R9 read over write");
    bank0Val = 8'hFF; bank1Val = 8'h00;
    runOp(3'b111, 2'd1, 1'b1, 8'hF0, 0, 0, "R9 detect over all");
    check("R9 detect flags", {28'h0, int50Present, int68Present, extPresent, romPresent},
          {28'h0, 4'b0010});

    runOp(3'b001, 2'd0, 1'b0, 8'h68, 1, 1, "R2 requests while busy");
    bank0Val = 8'h77; bank1Val = 8'h77;
    runOp(3'b010, 2'd2, 1'b0, 8'h00, 0, 1, "R2 requests during read");

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule